// File: doc/BRIEF.md
# Masked SIMD Lane Bitwise OR Unit

This unit is a single-cycle vector execution stage. It combines two packed operands made of 32-bit lanes with a bitwise OR. It produces the full 512-bit image of the destination register. The operation treats floating-point data only as bit patterns, so it raises no arithmetic exceptions and has no exception output.

A vector-length select limits which lanes are computed. Every bit above the selected length is cleared. A per-lane write mask decides which lanes inside the length are written; lanes that are masked off either keep the old destination value (merge) or become zero (zero mode). When the second operand comes from memory, it can be broadcast: its low 32 bits are then used in every lane.

A legacy flag selects the older 128-bit form. In that form the upper 384 bits of the old destination pass through unchanged. Masking, broadcast and the length select do not apply in that form. The result and `out_valid` are registered on the clock edge that accepts `in_valid`.

Top module: `masked_lane_or`

## Requirements
- R1: For `vlen_sel` 0, 1 and 2 the unit processes 4, 8 and 16 lanes (128, 256, 512 bits). For each active, written lane j, `out_dst[32j+31:32j]` is `src_a` lane j OR the second operand lane j.
- R2: A `vlen_sel` value of 3 behaves exactly like 0 (128 bits).
- R3: When `legacy` is 0, every `out_dst` bit at or above the vector length is 0.
- R4: When `bcast` and `b_is_mem` are both 1, every active lane uses `src_b[31:0]` as its second operand.
- R5: When `b_is_mem` is 0, `bcast` has no effect on the result.
- R6: When `mask_en` is 1, lane j inside the length is written only if `lane_mask[j]` is 1. With `zero_mode` 0, a lane that is masked off takes the matching lane of `old_dst`.
- R7: When `mask_en` is 1 and `zero_mode` is 1, a lane that is masked off inside the length is 0.
- R8: When `mask_en` is 0, `lane_mask` and `zero_mode` are ignored and all lanes inside the length are written.
- R9: When `legacy` is 1, lanes 0 to 3 are `src_a` OR `src_b`, and bits 511:128 equal `old_dst[511:128]`. In this form `vlen_sel`, `mask_en`, `lane_mask`, `zero_mode` and `bcast` are ignored.
- R10: Reset clears `out_valid` and `out_dst`. Each cycle with `in_valid` high produces `out_valid` high on the next cycle. `out_valid` is low after a cycle without `in_valid`.
- R11: `out_dst` holds its value after any cycle where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| vlen_sel | input | 2 | Vector length: 0=128, 1=256, 2=512, 3 treated as 128 |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| b_is_mem | input | 1 | Second source comes from memory |
| bcast | input | 1 | Broadcast the low lane of the second source |
| lane_mask | input | 16 | Per-lane write mask |
| mask_en | input | 1 | Enable write masking |
| zero_mode | input | 1 | Masked-off lanes: 1 = zero, 0 = merge |
| legacy | input | 1 | Legacy 128-bit form, upper bits preserved |
| old_dst | input | 512 | Previous destination value |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_dst | output | 512 | New destination value |

## Verification
The bench fills `old_dst` with a distinct, nonzero pattern. That exposes a design which clears bits above the length in legacy form, or which leaves old data there in the other forms. It also catches a design that confuses merge with zero for masked-off lanes.

Broadcast is tested with the second operand marked as a register. A design that ignores the memory qualifier would then copy lane 0 of `src_b` across all lanes. Code 3 for the length is checked against the 128-bit result, which catches a design that decodes it as 512 bits.

Two further stimuli target the mask path. In legacy form the mask is all zeros with zero mode set, so a design that applies the mask there would clear lanes. With masking disabled, an arbitrary mask is applied and must change nothing.

// File: rtl/masked_lane_or.sv
module masked_lane_or #(
  parameter int LANE_W = 32,
  parameter int LANES  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [1:0]                vlen_sel,
  input  logic [LANE_W*LANES-1:0]   src_a,
  input  logic [LANE_W*LANES-1:0]   src_b,
  input  logic                      b_is_mem,
  input  logic                      bcast,
  input  logic [LANES-1:0]          lane_mask,
  input  logic                      mask_en,
  input  logic                      zero_mode,
  input  logic                      legacy,
  input  logic [LANE_W*LANES-1:0]   old_dst,
  output logic                      out_valid,
  output logic [LANE_W*LANES-1:0]   out_dst
);
  localparam int DST_W = LANE_W * LANES;
  localparam logic [LANES-1:0] QTR_LANES  = LANES'((1 << (LANES / 4)) - 1);
  localparam logic [LANES-1:0] HALF_LANES = LANES'((1 << (LANES / 2)) - 1);
  localparam logic [LANES-1:0] ALL_LANES  = '1;

  logic [LANES-1:0] in_len;
  logic [LANES-1:0] write_en;
  logic             use_bc;
  logic [DST_W-1:0] result;

  always_comb begin
    if (legacy)
      in_len = QTR_LANES;
    else begin
      case (vlen_sel)
        2'd1:    in_len = HALF_LANES;
        2'd2:    in_len = ALL_LANES;
        default: in_len = QTR_LANES;
      endcase
    end
  end

  assign write_en = (mask_en && !legacy) ? lane_mask : ALL_LANES;
  assign use_bc   = bcast && b_is_mem && !legacy;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l, old_l;
    assign a_l   = src_a[j*LANE_W +: LANE_W];
    assign b_l   = use_bc ? src_b[LANE_W-1:0] : src_b[j*LANE_W +: LANE_W];
    assign old_l = old_dst[j*LANE_W +: LANE_W];
    assign result[j*LANE_W +: LANE_W] =
        !in_len[j]   ? (legacy ? old_l : '0) :
        !write_en[j] ? (zero_mode ? '0 : old_l) :
                       (a_l | b_l);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dst   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_dst <= result;
    end
  end

  // R3
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !legacy && vlen_sel != 2'd2 |=> out_dst[DST_W-1:DST_W/2] == '0);

  // R9
  legacy_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && legacy |=> out_dst[DST_W-1:DST_W/4] == $past(old_dst[DST_W-1:DST_W/4]));

  // R7
  zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !legacy && mask_en && zero_mode && !lane_mask[0] |=> out_dst[LANE_W-1:0] == '0);

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_dst));
endmodule

// File: tb/masked_lane_or_tb.sv
module masked_lane_or_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   vlen_sel = '0;
  logic [511:0] src_a = '0, src_b = '0, old_dst = '0;
  logic         b_is_mem = 1'b0, bcast = 1'b0, mask_en = 1'b0, zero_mode = 1'b0, legacy = 1'b0;
  logic [15:0]  lane_mask = '0;
  logic         out_valid;
  logic [511:0] out_dst;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  masked_lane_or dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen_sel(vlen_sel),
    .src_a(src_a), .src_b(src_b), .b_is_mem(b_is_mem), .bcast(bcast),
    .lane_mask(lane_mask), .mask_en(mask_en), .zero_mode(zero_mode),
    .legacy(legacy), .old_dst(old_dst), .out_valid(out_valid), .out_dst(out_dst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [511:0] pattern(input int seed);
    logic [511:0] v;
    for (int j = 0; j < 16; j++)
      v[j*32 +: 32] = (32'(seed) * 32'h9E37_79B1) ^ (32'(j) << 20) ^ 32'h0000_0101;
    return v;
  endfunction

  function automatic logic [511:0] expect_dst();
    logic [511:0] e = '0;
    int n;
    if (legacy) begin
      e = old_dst;
      e[127:0] = src_a[127:0] | src_b[127:0];
      return e;
    end
    n = (vlen_sel == 2'd2) ? 16 : (vlen_sel == 2'd1) ? 8 : 4;
    for (int j = 0; j < n; j++) begin
      logic [31:0] b;
      b = (bcast && b_is_mem) ? src_b[31:0] : src_b[j*32 +: 32];
      if (!mask_en || lane_mask[j]) e[j*32 +: 32] = src_a[j*32 +: 32] | b;
      else if (!zero_mode)          e[j*32 +: 32] = old_dst[j*32 +: 32];
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic run_op(input string req);
    logic [511:0] e;
    logic [511:0] prev;
    e = expect_dst();
    in_valid = 1'b1;
    @(negedge clk);
    check({req, " out_valid R10"}, {511'd0, out_valid}, 512'd1);
    check(req, out_dst, e);
    in_valid = 1'b0;
    prev = out_dst;
    src_a = ~src_a; old_dst = ~old_dst;
    @(negedge clk);
    check("R10 valid drop", {511'd0, out_valid}, 512'd0);
    check("R11 hold", out_dst, prev);
  endtask

  task automatic set_base(input int seed);
    src_a = pattern(seed); src_b = pattern(seed + 7); old_dst = pattern(seed + 13);
    b_is_mem = 1'b0; bcast = 1'b0; mask_en = 1'b0; zero_mode = 1'b0; legacy = 1'b0;
    lane_mask = '0; vlen_sel = 2'd2;
  endtask

  task automatic t_reset();
    check("R10 reset valid", {511'd0, out_valid}, 512'd0);
    check("R10 reset dst", out_dst, '0);
  endtask

  task automatic t_lengths();
    set_base(1); vlen_sel = 2'd2; run_op("R1 512");
    set_base(2); vlen_sel = 2'd1; run_op("R1 R3 256");
    set_base(3); vlen_sel = 2'd0; run_op("R1 R3 128");
    set_base(4); vlen_sel = 2'd3; run_op("R2 code3");
  endtask

  task automatic t_bcast();
    set_base(5); b_is_mem = 1'b1; bcast = 1'b1; run_op("R4 broadcast");
    set_base(6); b_is_mem = 1'b0; bcast = 1'b1; run_op("R5 reg bcast ignored");
  endtask

  task automatic t_mask();
    set_base(7); mask_en = 1'b1; lane_mask = 16'hA5C3; run_op("R6 merge");
    set_base(8); mask_en = 1'b1; zero_mode = 1'b1; lane_mask = 16'h3C5A; run_op("R7 zero");
    set_base(9); mask_en = 1'b1; zero_mode = 1'b1; lane_mask = 16'h00F0; vlen_sel = 2'd1;
    run_op("R7 R3 zero 256");
    set_base(10); mask_en = 1'b0; zero_mode = 1'b1; lane_mask = 16'h0001; run_op("R8 mask off");
  endtask

  task automatic t_legacy();
    set_base(11); legacy = 1'b1; vlen_sel = 2'd2; mask_en = 1'b1; zero_mode = 1'b1;
    lane_mask = '0; b_is_mem = 1'b1; bcast = 1'b1; run_op("R9 legacy");
  endtask

  task automatic t_back_to_back();
    logic [511:0] e1, e2;
    set_base(12); e1 = expect_dst();
    in_valid = 1'b1;
    @(negedge clk);
    check("R10 b2b first", out_dst, e1);
    src_a = pattern(20); vlen_sel = 2'd1; e2 = expect_dst();
    @(negedge clk);
    check("R10 b2b valid", {511'd0, out_valid}, 512'd1);
    check("R1 b2b second", out_dst, e2);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 b2b drop", {511'd0, out_valid}, 512'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_lengths();
    t_bcast();
    t_mask();
    t_legacy();
    t_back_to_back();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule